// File: doc/BRIEF.md
# Diagnostic Cache Valid Tracker

This block holds a small direct-mapped cache data store that covers a low-memory window. It keeps one valid bit for every 8-byte line and a set of three diagnostic registers. Firmware uses these registers to test whether accesses hit or miss. A read of an invalid line fills that line and raises a sticky miss flag. The flag changes only through a clear strobe, which copies a pending-miss latch into it. Two-bit mode transitions in the diagnostic register either arm that latch or invalidate the whole store.

The register port has a 2-bit offset and exposes three registers:
- CFG at offset 0: plain storage.
- ROUTE at offset 1: bit 4 enables routing.
- DIAG at offset 2: the miss flag sits in bit 7, the clear strobe in bit 1, and the mode pair in bits 5 and 0.

The block drives two outputs. `route_cache` tells the surrounding memory map to send low-memory accesses to this store instead of main RAM. `rom_timing` selects slow ROM timing for shadowed areas.

The window size is set by `ADDR_W`. A value of 16 gives a 64 KiB window and 13 gives 8 KiB; the default is a 1 KiB window. An external flush input invalidates every line, for example after a DMA transfer into the window.

Top module: `diag_cache_tracker`

## Requirements
- R1: After reset, CFG reads 0x00, ROUTE reads 0x02, DIAG reads 0x00, both select outputs are low, the pending latch is clear and every line is invalid. Stored data is not reset.
- R2: A memory read of an invalid line returns the stored byte one cycle later, marks the line valid and sets DIAG bit 7.
- R3: A memory read of a valid line returns the stored byte, clears the pending latch and leaves DIAG bit 7 unchanged.
- R4: A memory write stores the byte at its address and changes no valid bit and no DIAG bit.
- R5: A register write to DIAG stores written bits 6..4 and 2..0, forces bit 3 to 0 and leaves bit 7 as it was.
- R6: A DIAG write with written bit 1 set loads DIAG bit 7 from the pending latch and then clears the latch.
- R7: A DIAG write that moves the pair (bit 5, bit 0) into (1,0) from any other value sets the pending latch. Rewriting the same pair does not.
- R8: A DIAG write that moves the pair (bit 5, bit 0) into (0,1) from any other value invalidates every line in one cycle. Rewriting the same pair does not.
- R9: A high `flush_in` invalidates every line in one cycle.
- R10: `route_cache` is high exactly when ROUTE bit 4 is 1 and the DIAG pair is (1,0). `rom_timing` equals DIAG bit 0.
- R11: Offsets 0, 1 and 2 read back their stored values, and offset 3 reads 0xFF.
- R12: When an invalidation and a memory read fall in the same cycle, the invalidation wins. The read counts as a miss and sets DIAG bit 7, and every line, including the one read, is invalid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel | input | 1 | Register access strobe |
| io_we | input | 1 | Register write when high, read otherwise |
| io_addr | input | 2 | Register offset (0 CFG, 1 ROUTE, 2 DIAG, 3 unused) |
| io_wdata | input | 8 | Register write data |
| io_rdata | output | 8 | Register read data, combinational |
| mem_en | input | 1 | Window access strobe |
| mem_we | input | 1 | Window write when high, read otherwise |
| mem_addr | input | ADDR_W | Byte address inside the window |
| mem_wdata | input | 8 | Window write data |
| mem_rdata | output | 8 | Window read data, valid the cycle after a read |
| flush_in | input | 1 | Invalidate all lines |
| route_cache | output | 1 | Send low-memory accesses to this store |
| rom_timing | output | 1 | Use ROM timing for shadowed areas |

## Verification
A corrupted valid bit shows only on the next read of that line, when DIAG bit 7 does or does not rise. The flag is visible on the register port one cycle after that read. A corrupted pending latch stays hidden until the next clear strobe, so every arming or hit in the test is followed by a strobe and a DIAG readback. Transition checks rewrite the same mode pair and then re-read a line, which exposes an invalidation or arming that reacted to a level instead of a change.

// File: rtl/diag_cache_tracker.sv
module diag_cache_tracker #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_sel,
  input  logic              io_we,
  input  logic [1:0]        io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              mem_en,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_wdata,
  output logic [7:0]        mem_rdata,
  input  logic              flush_in,
  output logic              route_cache,
  output logic              rom_timing
);
  localparam int BYTES  = 2 ** ADDR_W;
  localparam int LINE_W = ADDR_W - 3;
  localparam int LINES  = 2 ** LINE_W;

  logic [7:0]       store [BYTES];
  logic [LINES-1:0] valid;
  logic [7:0]       cfg_q, route_q;
  logic [6:0]       diag_lo;
  logic             miss_flag, pending;

  wire [LINE_W-1:0] line   = mem_addr[ADDR_W-1:3];
  wire              rd     = mem_en & ~mem_we;
  wire              wr     = mem_en & mem_we;
  wire              io_wr  = io_sel & io_we;
  wire              diag_wr = io_wr && io_addr == 2'd2;
  wire [1:0]        old_pair = {diag_lo[5], diag_lo[0]};
  wire [1:0]        new_pair = {io_wdata[5], io_wdata[0]};
  wire              arm    = diag_wr && new_pair == 2'b10 && old_pair != 2'b10;
  wire              inv    = (diag_wr && new_pair == 2'b01 && old_pair != 2'b01) | flush_in;
  wire              hit    = rd & valid[line] & ~inv;
  wire              miss   = rd & ~hit;
  wire              strobe = diag_wr & io_wdata[1];
  wire              flag_d = (strobe ? pending : miss_flag) | miss;

  always_ff @(posedge clk) begin
    if (wr) store[mem_addr] <= mem_wdata;
    if (rd) mem_rdata <= store[mem_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
    end else if (inv) begin
      valid <= '0;
    end else if (miss) begin
      valid[line] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= 8'h00;
      route_q   <= 8'h02;
      diag_lo   <= 7'h00;
      miss_flag <= 1'b0;
      pending   <= 1'b0;
    end else begin
      miss_flag <= flag_d;
      if (io_wr && io_addr == 2'd0) cfg_q   <= io_wdata;
      if (io_wr && io_addr == 2'd1) route_q <= io_wdata;
      if (diag_wr) diag_lo <= io_wdata[6:0] & 7'h77;
      if (arm)         pending <= 1'b1;
      else if (strobe) pending <= 1'b0;
      else if (hit)    pending <= 1'b0;
    end
  end

  always_comb begin
    case (io_addr)
      2'd0:    io_rdata = cfg_q;
      2'd1:    io_rdata = route_q;
      2'd2:    io_rdata = {miss_flag, diag_lo};
      default: io_rdata = 8'hFF;
    endcase
  end

  assign route_cache = route_q[4] & diag_lo[5] & ~diag_lo[0];
  assign rom_timing  = diag_lo[0];

  AST_MISS_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !valid[line]) |=> miss_flag); // R2
  AST_MISS_FILLS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !valid[line] && !inv) |=> valid[$past(line)]); // R2
  AST_HIT_DROPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && valid[line] && !inv && !arm) |=> !pending); // R3
  AST_WRITE_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !inv) |=> valid == $past(valid)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_flag && !strobe) |=> miss_flag); // R5
  AST_ARM_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> pending); // R7
  AST_INV_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    inv |=> valid == '0); // R8
endmodule

// File: tb/test_diag_cache_tracker.sv
`timescale 1ns/1ps
module test_diag_cache_tracker;
  localparam int AW = 10;
  localparam logic [2:0] OW = 3'd0, OR = 3'd1, MW = 3'd2, MR = 3'd3, FL = 3'd4, CP = 3'd5;

  typedef struct packed {
    logic [2:0] op;
    logic [9:0] a;
    logic [7:0] d;
    logic [7:0] e;
    logic [3:0] r;
  } vec_t;

  localparam int N = 64;
  localparam vec_t TBL [N] = '{
    '{OR,10'h0,8'h00,8'h00,4'd1},   // R1
    '{OR,10'h1,8'h00,8'h02,4'd1},   // R1
    '{OR,10'h2,8'h00,8'h00,4'd1},   // R1
    '{OR,10'h3,8'h00,8'hFF,4'd11},  // R11
    '{MW,10'h010,8'hA5,8'h00,4'd4}, // R4
    '{OR,10'h2,8'h00,8'h00,4'd4},   // R4
    '{MR,10'h010,8'h00,8'hA5,4'd2}, // R2
    '{OR,10'h2,8'h00,8'h80,4'd2},   // R2
    '{OW,10'h2,8'h02,8'h00,4'd6},
    '{OR,10'h2,8'h00,8'h02,4'd6},   // R6
    '{MW,10'h011,8'h3C,8'h00,4'd4},
    '{MR,10'h011,8'h00,8'h3C,4'd3}, // R3
    '{OR,10'h2,8'h00,8'h02,4'd3},   // R3
    '{OW,10'h2,8'h20,8'h00,4'd7},
    '{OR,10'h2,8'h00,8'h20,4'd5},   // R5
    '{MR,10'h010,8'h00,8'hA5,4'd3}, // R3
    '{OW,10'h2,8'h22,8'h00,4'd3},
    '{OR,10'h2,8'h00,8'h22,4'd3},   // R3
    '{OW,10'h2,8'h20,8'h00,4'd7},
    '{OW,10'h2,8'h22,8'h00,4'd7},
    '{OR,10'h2,8'h00,8'h22,4'd7},   // R7
    '{OW,10'h2,8'h00,8'h00,4'd7},
    '{OW,10'h2,8'h20,8'h00,4'd7},
    '{OW,10'h2,8'h22,8'h00,4'd7},
    '{OR,10'h2,8'h00,8'hA2,4'd7},   // R7
    '{OW,10'h2,8'h22,8'h00,4'd6},
    '{OR,10'h2,8'h00,8'h22,4'd6},   // R6
    '{OW,10'h2,8'hFF,8'h00,4'd5},
    '{OR,10'h2,8'h00,8'h77,4'd5},   // R5
    '{MW,10'h040,8'h11,8'h00,4'd4},
    '{MR,10'h040,8'h00,8'h11,4'd2}, // R2
    '{OR,10'h2,8'h00,8'hF7,4'd2},   // R2
    '{OW,10'h2,8'h04,8'h00,4'd5},
    '{OR,10'h2,8'h00,8'h84,4'd5},   // R5
    '{OW,10'h2,8'h01,8'h00,4'd8},
    '{OW,10'h2,8'h02,8'h00,4'd8},
    '{MR,10'h010,8'h00,8'hA5,4'd8}, // R8
    '{OR,10'h2,8'h00,8'h82,4'd8},   // R8
    '{OW,10'h2,8'h03,8'h00,4'd8},
    '{MR,10'h010,8'h00,8'hA5,4'd8},
    '{OW,10'h2,8'h01,8'h00,4'd8},
    '{OW,10'h2,8'h03,8'h00,4'd8},
    '{MR,10'h010,8'h00,8'hA5,4'd8},
    '{OR,10'h2,8'h00,8'h03,4'd8},   // R8
    '{FL,10'h0,8'h00,8'h00,4'd9},
    '{MR,10'h010,8'h00,8'hA5,4'd9}, // R9
    '{OR,10'h2,8'h00,8'h83,4'd9},   // R9
    '{OW,10'h0,8'h5A,8'h00,4'd11},
    '{OR,10'h0,8'h00,8'h5A,4'd11},  // R11
    '{OW,10'h1,8'h13,8'h00,4'd11},
    '{OR,10'h1,8'h00,8'h13,4'd11},  // R11
    '{OW,10'h3,8'h00,8'h00,4'd11},
    '{OR,10'h3,8'h00,8'hFF,4'd11},  // R11
    '{OW,10'h2,8'h20,8'h00,4'd10},
    '{CP,10'h0,8'h00,8'h01,4'd10},  // R10
    '{OW,10'h1,8'h03,8'h00,4'd10},
    '{CP,10'h0,8'h00,8'h00,4'd10},  // R10
    '{OW,10'h2,8'h21,8'h00,4'd10},
    '{CP,10'h0,8'h00,8'h02,4'd10},  // R10
    '{OW,10'h2,8'h02,8'h00,4'd7},
    '{OR,10'h2,8'h00,8'h82,4'd7},   // R7
    '{MR,10'h010,8'h00,8'hA5,4'd3}, // R3
    '{OW,10'h2,8'h02,8'h00,4'd6},
    '{OR,10'h2,8'h00,8'h02,4'd6}    // R6
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic io_sel = 1'b0, io_we = 1'b0, mem_en = 1'b0, mem_we = 1'b0, flush_in = 1'b0;
  logic [1:0] io_addr = '0;
  logic [7:0] io_wdata = '0, mem_wdata = '0, io_rdata, mem_rdata;
  logic [AW-1:0] mem_addr = '0;
  logic route_cache, rom_timing;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  diag_cache_tracker #(.ADDR_W(AW)) i_diag_cache_tracker (
    .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_we(io_we), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .flush_in(flush_in), .route_cache(route_cache), .rom_timing(rom_timing));

  task automatic chk(input int r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: got %02h expected %02h", r, act, exp);
    end
  endtask

  task automatic idle();
    io_sel = 0; io_we = 0; mem_en = 0; mem_we = 0; flush_in = 0;
  endtask

  task automatic run(input vec_t v);
    @(negedge clk);
    idle();
    case (v.op)
      OW: begin io_sel = 1; io_we = 1; io_addr = v.a[1:0]; io_wdata = v.d; end
      OR: io_addr = v.a[1:0];
      MW: begin mem_en = 1; mem_we = 1; mem_addr = v.a; mem_wdata = v.d; end
      MR: begin mem_en = 1; mem_addr = v.a; end
      FL: flush_in = 1;
      default: ;
    endcase
    @(posedge clk);
    #1;
    case (v.op)
      OR: chk(int'(v.r), io_rdata, v.e);
      MR: chk(int'(v.r), mem_rdata, v.e);
      CP: chk(int'(v.r), {6'd0, rom_timing, route_cache}, v.e);
      default: ;
    endcase
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    chk(1, {6'd0, rom_timing, route_cache}, 8'h00); // R1 outputs low
    for (int i = 0; i < N; i++) run(TBL[i]);

    // R12: invalidating write and read of a valid line in one cycle
    @(negedge clk);
    idle();
    io_sel = 1; io_we = 1; io_addr = 2'd2; io_wdata = 8'h01;
    mem_en = 1; mem_addr = 10'h010;
    @(posedge clk); #1;
    chk(12, mem_rdata, 8'hA5);
    run('{OR,10'h2,8'h00,8'h81,4'd12});  // R12 read counted as miss
    run('{OW,10'h2,8'h03,8'h00,4'd12});
    run('{MR,10'h010,8'h00,8'hA5,4'd12});
    run('{OR,10'h2,8'h00,8'h83,4'd12});  // R12 line stayed invalid

    // R1: reset in mid-run
    run('{OW,10'h0,8'h77,8'h00,4'd1});
    run('{OW,10'h1,8'h10,8'h00,4'd1});
    run('{OW,10'h2,8'h20,8'h00,4'd1});
    @(negedge clk); idle(); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(1, {6'd0, rom_timing, route_cache}, 8'h00);
    run('{OR,10'h0,8'h00,8'h00,4'd1});
    run('{OR,10'h1,8'h00,8'h02,4'd1});
    run('{OR,10'h2,8'h00,8'h00,4'd1});
    run('{OW,10'h2,8'h02,8'h00,4'd1});
    run('{OR,10'h2,8'h00,8'h02,4'd1});   // R1 pending latch cleared
    run('{MR,10'h010,8'h00,8'hA5,4'd1});
    run('{OR,10'h2,8'h00,8'h82,4'd1});   // R1 lines invalid
    @(negedge clk); idle();
    finish_run();
  end
endmodule